// File: doc/BRIEF.md
# Polled Character Output Port

This block is a character output port that sits on a 16-bit, word-addressed processor bus and exposes two registers. One is a status word whose most significant bit reports that the port can take a new character. The other is a data register that takes that character. Software polls the status word until the flag reads one, then writes a character to the data register. The port latches the low eight bits of the write, clears its flag, and offers the character to a downstream display sink over a valid/ready handshake.

The flag stays low until the sink consumes the character. While the port is busy, any further write to the data register is dropped without notice. The held character does not change until the next write that is accepted. A read of the data register returns the character the port last took, zero-extended to the bus width. A read of any address other than the two registers returns zero. Writes to the status word, or to any other address, change nothing.

Top module: `char_out_port`

## Requirements
- R1: After reset the status word reads 0x8000, `snk_valid` is low and the data register reads 0x0000.
- R2: A read of the status address (0xFE04) returns the ready flag in bit 15 and zero in bits 14 to 0. The read data is combinational in the same cycle as `bus_rd`.
- R3: A write to the data address (0xFE06) while the flag is one has two effects on the next cycle. The low eight write bits appear on `snk_char` with `snk_valid` high, and the flag reads zero.
- R4: A write to the data address while the flag is zero is discarded, and the held character keeps its value. A burst of back-to-back writes therefore yields exactly one character for each sink acceptance.
- R5: In a cycle where `snk_valid` and `snk_ready` are both high, the character is consumed. On the next cycle `snk_valid` is low and the flag reads one.
- R6: A read of the data address returns the held character in bits 7 to 0 and zero in bits 15 to 8, whatever the upper bits of the write were.
- R7: A write to the status address or to any other address changes neither the flag nor the held character.
- R8: While `snk_valid` is high and `snk_ready` is low, `snk_valid` stays high and `snk_char` stays stable.
- R9: A read of any address other than the two registers, or any cycle with `bus_rd` low, returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Word address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 16 | Read data, combinational |
| snk_char | output | 8 | Character offered to the display sink |
| snk_valid | output | 1 | Character pending for the sink |
| snk_ready | input | 1 | Sink can consume the character this cycle |

## Verification
The bench builds the port with its default widths and addresses: a 16-bit bus, an 8-bit character and the two fixed register addresses. The character is only eight bits wide, so all 256 codes go through a full cycle of write, busy write and acceptance. The upper write bits are scrambled on every pass, and the sink stalls for a different number of cycles each time. The flag and the held character are small enough to cover every decode outcome: writes to the status address, to neighbouring addresses and to the data address while busy. Back-to-back bursts check, with the sink held ready and with the sink stalled, that the number of characters consumed matches the arithmetic prediction.

// File: rtl/char_out_port.sv
module char_out_port #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CHAR_W = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hFE04,
  parameter logic [ADDR_W-1:0] CHAR_ADDR = 16'hFE06
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [CHAR_W-1:0] snk_char,
  output logic              snk_valid,
  input  logic              snk_ready
);
  localparam int PAD_W = DATA_W - CHAR_W;

  logic              free_q;
  logic [CHAR_W-1:0] char_q;

  wire hit_stat = bus_addr == STAT_ADDR;
  wire hit_char = bus_addr == CHAR_ADDR;
  wire take     = bus_wr && hit_char && free_q;
  wire drain    = !free_q && snk_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      free_q <= 1'b1;
      char_q <= '0;
    end else begin
      if (take) begin
        free_q <= 1'b0;
        char_q <= bus_wdata[CHAR_W-1:0];
      end else if (drain) begin
        free_q <= 1'b1;
      end
    end
  end

  assign snk_valid = !free_q;
  assign snk_char  = char_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (hit_stat)      bus_rdata = {free_q, {(DATA_W-1){1'b0}}};
      else if (hit_char) bus_rdata = {{PAD_W{1'b0}}, char_q};
    end
  end
endmodule

module char_out_port_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CHAR_W = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hFE04,
  parameter logic [ADDR_W-1:0] CHAR_ADDR = 16'hFE06
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [CHAR_W-1:0] snk_char,
  input logic              snk_valid,
  input logic              snk_ready
);
  assert_status_layout_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == STAT_ADDR) |->
      (bus_rdata[DATA_W-2:0] == '0 && bus_rdata[DATA_W-1] == !snk_valid));

  assert_write_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!snk_valid && bus_wr && bus_addr == CHAR_ADDR) |=>
      (snk_valid && snk_char == $past(bus_wdata[CHAR_W-1:0])));

  assert_busy_write_dropped_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (snk_valid && bus_wr) |=> $stable(snk_char));

  assert_accept_frees_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (snk_valid && snk_ready) |=> !snk_valid);

  assert_data_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == CHAR_ADDR) |->
      (bus_rdata[DATA_W-1:CHAR_W] == '0 && bus_rdata[CHAR_W-1:0] == snk_char));

  assert_other_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!snk_valid && bus_wr && bus_addr != CHAR_ADDR) |=> (!snk_valid && $stable(snk_char)));

  assert_hold_while_stalled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (snk_valid && !snk_ready) |=> (snk_valid && $stable(snk_char)));

  assert_quiet_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd || (bus_addr != STAT_ADDR && bus_addr != CHAR_ADDR)) |-> bus_rdata == '0);
endmodule

bind char_out_port char_out_port_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHAR_W(CHAR_W),
  .STAT_ADDR(STAT_ADDR), .CHAR_ADDR(CHAR_ADDR)
) chk_i (.*);

// File: tb/char_out_port_tb.sv
`timescale 1ns/1ps
module char_out_port_tb_top;
  localparam logic [15:0] STAT = 16'hFE04;
  localparam logic [15:0] DREG = 16'hFE06;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_rdata;
  logic [7:0]  snk_char;
  logic        snk_valid;
  logic        snk_ready = 1'b0;

  int errors = 0;
  int checks = 0;
  int acc_n = 0;
  logic [7:0] acc_log [0:15];
  logic mon_en = 1'b0;

  always #2.5 clk = ~clk;

  char_out_port dut_i (.*);

  always @(negedge clk)
    if (mon_en && snk_valid && snk_ready) begin
      if (acc_n < 16) acc_log[acc_n] = snk_char;
      acc_n++;
    end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic do_read(input logic [15:0] a, output logic [15:0] v);
    bus_addr = a; bus_rd = 1'b1;
    #0.5 v = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic accept_once();
    snk_ready = 1'b1;
    @(posedge clk); #1;
    snk_ready = 1'b0;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    do_read(STAT, v); chk("R1 status", v, 16'h8000);
    do_read(DREG, v); chk("R1 data", v, 16'h0000);
    chk("R1 valid", {15'b0, snk_valid}, 16'h0000);
    // R9 reads elsewhere and without strobe
    for (int k = 0; k < 16; k++) begin
      do_read(16'hFE00 + 16'(k), v);
      if (16'hFE00 + 16'(k) == STAT) chk("R2 status sweep", v, 16'h8000);
      else if (16'hFE00 + 16'(k) == DREG) chk("R6 data sweep", v, 16'h0000);
      else chk("R9 other read", v, 16'h0000);
    end
    bus_addr = STAT; #0.5 chk("R9 no strobe", bus_rdata, 16'h0000);

    // R7 writes to status and neighbours do nothing
    for (int k = 0; k < 16; k++) begin
      if (16'hFE00 + 16'(k) != DREG) begin
        do_write(16'hFE00 + 16'(k), 16'hFFFF);
        chk("R7 valid", {15'b0, snk_valid}, 16'h0000);
      end
    end
    do_read(STAT, v); chk("R7 status", v, 16'h8000);
    do_read(DREG, v); chk("R7 data", v, 16'h0000);

    // full character sweep
    for (int c = 0; c < 256; c++) begin
      logic [7:0] ch;
      ch = 8'(c);
      do_write(DREG, {ch ^ 8'h5A, ch});
      chk("R3 valid", {15'b0, snk_valid}, 16'h0001);
      chk("R3 char", {8'h00, snk_char}, {8'h00, ch});
      do_read(STAT, v); chk("R3 status busy", v, 16'h0000);
      do_write(DREG, {8'hA5, ~ch});
      chk("R4 busy write dropped", {8'h00, snk_char}, {8'h00, ch});
      for (int w = 0; w < c % 4; w++) begin
        @(posedge clk); #1;
        chk("R8 held", {7'b0, snk_valid, snk_char}, {7'b0, 1'b1, ch});
      end
      do_write(STAT, 16'h8000);
      chk("R7 status write while busy", {15'b0, snk_valid}, 16'h0001);
      accept_once();
      chk("R5 valid drop", {15'b0, snk_valid}, 16'h0000);
      do_read(STAT, v); chk("R5 status", v, 16'h8000);
      do_read(DREG, v); chk("R6 data read", v, {8'h00, ch});
    end

    // R4 burst with sink always ready: every other write is taken
    acc_n = 0; mon_en = 1'b1; snk_ready = 1'b1;
    for (int i = 0; i < 8; i++) do_write(DREG, 16'h0040 + 16'(i));
    repeat (3) @(posedge clk); #1;
    snk_ready = 1'b0; mon_en = 1'b0;
    chk("R4 burst count", 16'(acc_n), 16'd4);
    for (int i = 0; i < 4; i++)
      chk("R4 burst char", {8'h00, acc_log[i]}, 16'h0040 + 16'(2 * i));

    // R4 burst with stalled sink: only the first write survives
    acc_n = 0; mon_en = 1'b1;
    for (int i = 0; i < 6; i++) do_write(DREG, 16'h0070 + 16'(i));
    chk("R4 stalled char", {8'h00, snk_char}, 16'h0070);
    accept_once();
    repeat (2) @(posedge clk); #1;
    mon_en = 1'b0;
    chk("R4 stalled count", 16'(acc_n), 16'd1);
    do_read(STAT, v); chk("R5 final status", v, 16'h8000);

    // R1 reset mid-transfer
    do_write(DREG, 16'h0033);
    rst_n = 1'b0; @(posedge clk); #1; rst_n = 1'b1;
    do_read(STAT, v); chk("R1 reset status", v, 16'h8000);
    do_read(DREG, v); chk("R1 reset data", v, 16'h0000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule